// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This block is a register-mapped peripheral that lets several processors pass 32-bit words to one another. It contains a parameterised set of mailboxes. Each mailbox is a short first-in first-out queue. A sender writes a word into a mailbox's message register, and a receiver reads that register to take out the oldest word. Each mailbox has two read-only registers beside its message register: one reports whether the queue is full, and the other reports how many words are waiting.

Every receiving agent, called a user, owns one interrupt line and three registers: an event status word, an enable-set register and an enable-clear register. The event word carries two bits per mailbox. Bit 2m is the new-message event of mailbox m and bit 2m+1 is its room-available event. A push or a pop raises the matching bit in the status word of every user at once. Each user selects the events it wants with its own enable mask, and clears the events it has handled by writing ones to its status register.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every mailbox is empty, every status and enable bit is zero, every interrupt line is low, and `bus_rdata` is zero.
- R2: Reading byte offset 0x000 returns the version: the major number in bits 7:4 and the minor number in bits 3:0. With the default parameters the value is 0x21.
- R3: Writing byte offset 0x040+4m pushes the written word into mailbox m when fewer than DEPTH words are queued. A write to a full mailbox is dropped, and the count and the contents stay unchanged.
- R4: Reading offset 0x040+4m returns the oldest word of mailbox m and removes it, so words leave in the order they arrived. The value appears on `bus_rdata` in the cycle after the read strobe and holds until the next accepted read. A read of an empty mailbox returns zero and changes nothing.
- R5: Offset 0x080+4m reads 1 while mailbox m is full and 0 otherwise. Offset 0x0C0+4m reads the number of queued words.
- R6: Every accepted push into mailbox m sets bit 2m of the status word of every user. Every accepted pop sets bit 2m+1 of every user's status word.
- R7: Offset 0x104+0x10u reads user u's raw status word. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Writing 1s to offset 0x108+0x10u sets enable bits of user u, and writing 1s to 0x10C+0x10u clears them. Zero bits have no effect. A read of either offset returns the current enable mask.
- R9: `irq_o[u]` is high exactly when user u's status AND enable is nonzero. It follows a register update in the next cycle.
- R10: Unmapped and misaligned offsets read zero. Writes to them, and to the read-only version, full and count registers, change nothing.
- R11: In a cycle where `bus_we` and `bus_re` are both high, the write is carried out and the read is ignored: no pop takes place and `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_re` |
| irq_o | output | N_USER | One interrupt line per user |

## Verification
The bench builds the block with its defaults: four mailboxes, two users and a queue depth of four. With a depth of four, a full mailbox and a dropped write are reached after four pushes, so the random phase crosses the full and empty boundaries many times. Four mailboxes fill an eight-bit event word in which the new-message and room-available bits interleave. Two users show that the enable masks are independent while a single event lands in both status words.

// File: rtl/ipc_mbox_pkg.sv
// Package: shared constants and types of the mailbox controller.
// Assumes byte addressing with 32-bit registers on word boundaries.
package ipc_mbox_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned OFS_VER    = 'h000;
    localparam int unsigned OFS_MSG    = 'h040;
    localparam int unsigned OFS_FULL   = 'h080;
    localparam int unsigned OFS_CNT    = 'h0C0;
    localparam int unsigned OFS_STAT   = 'h104;
    localparam int unsigned OFS_ENSET  = 'h108;
    localparam int unsigned OFS_ENCLR  = 'h10C;
    localparam int unsigned USR_STRIDE = 'h10;

    typedef enum logic [2:0] {
        RS_NONE, RS_VER, RS_MSG, RS_FULL, RS_CNT, RS_STAT, RS_EN
    } rsel_kind_e;

    typedef struct packed {
        rsel_kind_e  kind;
        logic [3:0]  idx;
    } rsel_t;
endpackage

// File: rtl/mbox_addr_dec.sv
// Module: address decoder of the mailbox controller.
// Turns one bus access into per-mailbox push/pop strobes, per-user register
// write strobes and a read selector. Assumes at most one register matches an
// address. A cycle with both strobes counts as a write only.
module mbox_addr_dec
    import ipc_mbox_pkg::*;
#(
    parameter int N_MBOX = 4,
    parameter int N_USER = 2,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic [N_MBOX-1:0] msg_wr_o,
    output logic [N_MBOX-1:0] msg_rd_o,
    output logic [N_USER-1:0] stat_wr_o,
    output logic [N_USER-1:0] enset_wr_o,
    output logic [N_USER-1:0] enclr_wr_o,
    output rsel_t             rsel_o,
    output logic              rd_go_o
);
    // Decode the offset against every mapped register.
    always_comb begin
        rd_go_o    = re_i & ~we_i;
        msg_wr_o   = '0;
        msg_rd_o   = '0;
        stat_wr_o  = '0;
        enset_wr_o = '0;
        enclr_wr_o = '0;
        rsel_o     = '0;
        if (addr_i == ADDR_W'(OFS_VER)) begin
            rsel_o.kind = RS_VER;
        end
        for (int m = 0; m < N_MBOX; m++) begin
            if (addr_i == ADDR_W'(OFS_MSG + WORD_BYTES * m)) begin
                msg_wr_o[m] = we_i;
                msg_rd_o[m] = re_i & ~we_i;
                rsel_o.kind = RS_MSG;
                rsel_o.idx  = 4'(m);
            end
            if (addr_i == ADDR_W'(OFS_FULL + WORD_BYTES * m)) begin
                rsel_o.kind = RS_FULL;
                rsel_o.idx  = 4'(m);
            end
            if (addr_i == ADDR_W'(OFS_CNT + WORD_BYTES * m)) begin
                rsel_o.kind = RS_CNT;
                rsel_o.idx  = 4'(m);
            end
        end
        for (int u = 0; u < N_USER; u++) begin
            if (addr_i == ADDR_W'(OFS_STAT + USR_STRIDE * u)) begin
                stat_wr_o[u] = we_i;
                rsel_o.kind  = RS_STAT;
                rsel_o.idx   = 4'(u);
            end
            if (addr_i == ADDR_W'(OFS_ENSET + USR_STRIDE * u)) begin
                enset_wr_o[u] = we_i;
                rsel_o.kind   = RS_EN;
                rsel_o.idx    = 4'(u);
            end
            if (addr_i == ADDR_W'(OFS_ENCLR + USR_STRIDE * u)) begin
                enclr_wr_o[u] = we_i;
                rsel_o.kind   = RS_EN;
                rsel_o.idx    = 4'(u);
            end
        end
    end
endmodule

// File: rtl/mbox_fifo.sv
// Module: one mailbox queue.
// Circular buffer of DEPTH words with an occupancy counter. A push into a
// full queue and a pop from an empty queue are refused. head_o is zero when
// the queue is empty. Storage words carry no reset; the counter guards them.
module mbox_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_req_i,
    input  logic                         pop_req_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o,
    output logic                         pushed_o,
    output logic                         popped_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Decide whether each request is accepted.
    always_comb begin
        full_o   = (cnt == CNT_W'(DEPTH));
        pushed_o = push_req_i & ~full_o;
        popped_o = pop_req_i & (cnt != '0);
        head_o   = (cnt != '0) ? mem[rd_ptr] : '0;
        count_o  = cnt;
    end

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (pushed_o) mem[wr_ptr] <= wdata_i;
    end

    // Advance the pointers and the occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (pushed_o) wr_ptr <= ptr_inc(wr_ptr);
            if (popped_o) rd_ptr <= ptr_inc(rd_ptr);
            case ({pushed_o, popped_o})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mbox_irq_unit.sv
// Module: event status, enable mask and interrupt line of one user.
// Events are set from the queues; writing ones clears status bits. Enable
// bits have separate set and clear strobes. A new event wins over a clear
// of the same bit in the same cycle.
module mbox_irq_unit #(
    parameter int EV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_i,
    input  logic            stat_wr_i,
    input  logic            enset_wr_i,
    input  logic            enclr_wr_i,
    input  logic [EV_W-1:0] wdata_i,
    output logic [EV_W-1:0] status_o,
    output logic [EV_W-1:0] enable_o,
    output logic            irq_o
);
    // Collect events and apply write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (stat_wr_i) begin
            status_o <= (status_o & ~wdata_i) | ev_i;
        end else begin
            status_o <= status_o | ev_i;
        end
    end

    // Maintain the enable mask from the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
        end else if (enset_wr_i) begin
            enable_o <= enable_o | wdata_i;
        end else if (enclr_wr_i) begin
            enable_o <= enable_o & ~wdata_i;
        end
    end

    // Raise the line while any enabled event is pending.
    always_comb irq_o = |(status_o & enable_o);
endmodule

// File: rtl/ipc_mailbox.sv
// Module: top of the interprocessor mailbox controller.
// Instantiates one queue per mailbox and one interrupt unit per user, and
// routes bus accesses through the decoder. Read data is registered.
// Assumes 2*N_MBOX <= 32 and N_MBOX, N_USER <= 16.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int N_MBOX    = 4,
    parameter int N_USER    = 2,
    parameter int DEPTH     = 4,
    parameter int ADDR_W    = 9,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic [N_USER-1:0] irq_o
);
    localparam int EV_W  = 2 * N_MBOX;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [N_MBOX-1:0] msg_wr, msg_rd, full, pushed, popped;
    logic [N_USER-1:0] stat_wr, enset_wr, enclr_wr;
    rsel_t             rsel;
    logic              rd_go;
    logic [31:0]       head [N_MBOX];
    logic [CNT_W-1:0]  cnt  [N_MBOX];
    logic [EV_W-1:0]   ev;
    logic [EV_W-1:0]   status [N_USER];
    logic [EV_W-1:0]   enable [N_USER];
    logic [31:0]       rd_val;
    logic [N_MBOX*CNT_W-1:0] cnt_flat;
    logic [N_USER*EV_W-1:0]  status_flat;

    mbox_addr_dec #(.N_MBOX(N_MBOX), .N_USER(N_USER), .ADDR_W(ADDR_W)) u_dec (
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .re_i       (bus_re),
        .msg_wr_o   (msg_wr),
        .msg_rd_o   (msg_rd),
        .stat_wr_o  (stat_wr),
        .enset_wr_o (enset_wr),
        .enclr_wr_o (enclr_wr),
        .rsel_o     (rsel),
        .rd_go_o    (rd_go)
    );

    for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
        mbox_fifo #(.DEPTH(DEPTH), .DATA_W(32)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_req_i (msg_wr[m]),
            .pop_req_i  (msg_rd[m]),
            .wdata_i    (bus_wdata),
            .head_o     (head[m]),
            .count_o    (cnt[m]),
            .full_o     (full[m]),
            .pushed_o   (pushed[m]),
            .popped_o   (popped[m])
        );
        assign ev[2*m]     = pushed[m];
        assign ev[2*m + 1] = popped[m];
        assign cnt_flat[m*CNT_W +: CNT_W] = cnt[m];
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_user
        mbox_irq_unit #(.EV_W(EV_W)) u_irq (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ev),
            .stat_wr_i  (stat_wr[u]),
            .enset_wr_i (enset_wr[u]),
            .enclr_wr_i (enclr_wr[u]),
            .wdata_i    (bus_wdata[EV_W-1:0]),
            .status_o   (status[u]),
            .enable_o   (enable[u]),
            .irq_o      (irq_o[u])
        );
        assign status_flat[u*EV_W +: EV_W] = status[u];
    end

    // Select the value returned for the addressed register.
    always_comb begin
        rd_val = '0;
        case (rsel.kind)
            RS_VER: rd_val = {24'b0, 4'(VER_MAJOR), 4'(VER_MINOR)};
            RS_MSG, RS_FULL, RS_CNT: begin
                for (int m = 0; m < N_MBOX; m++) begin
                    if (rsel.idx == 4'(m)) begin
                        if (rsel.kind == RS_MSG)       rd_val = head[m];
                        else if (rsel.kind == RS_FULL) rd_val = {31'b0, full[m]};
                        else                           rd_val = 32'(cnt[m]);
                    end
                end
            end
            RS_STAT, RS_EN: begin
                for (int u = 0; u < N_USER; u++) begin
                    if (rsel.idx == 4'(u)) begin
                        rd_val = (rsel.kind == RS_STAT) ? 32'(status[u]) : 32'(enable[u]);
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Register read data on an accepted read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Module: assertion checker for the mailbox controller, bound to its top.
// Observes the bus, the interrupt lines and the queue counts and status
// words that the sub-blocks drive.
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
#(
    parameter int N_MBOX = 4,
    parameter int N_USER = 2,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 3,
    parameter int EV_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_we,
    input logic                     bus_re,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic [N_USER-1:0]        irq_o,
    input logic [N_MBOX*CNT_W-1:0]  cnt_flat,
    input logic [N_USER*EV_W-1:0]   status_flat
);
    for (genvar m = 0; m < N_MBOX; m++) begin : g_m
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[m*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

        assert_push_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(OFS_MSG + WORD_BYTES * m)
                && cnt_flat[m*CNT_W +: CNT_W] < CNT_W'(DEPTH))
            |=> cnt_flat[m*CNT_W +: CNT_W] == $past(cnt_flat[m*CNT_W +: CNT_W]) + CNT_W'(1));

        assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && !bus_we && bus_addr == ADDR_W'(OFS_MSG + WORD_BYTES * m)
                && cnt_flat[m*CNT_W +: CNT_W] == '0)
            |=> (bus_rdata == '0 && cnt_flat[m*CNT_W +: CNT_W] == '0));

        for (genvar u = 0; u < N_USER; u++) begin : g_u
            assert_newmsg_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == ADDR_W'(OFS_MSG + WORD_BYTES * m)
                    && cnt_flat[m*CNT_W +: CNT_W] < CNT_W'(DEPTH))
                |=> status_flat[u*EV_W + 2*m]);
        end
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_irq
        assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(OFS_ENCLR + USR_STRIDE * u)
                && bus_wdata[EV_W-1:0] == '1)
            |=> !irq_o[u]);
    end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .N_MBOX (N_MBOX),
    .N_USER (N_USER),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .EV_W   (EV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .cnt_flat    (cnt_flat),
    .status_flat (status_flat)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, checked
// against a queue-and-mask model kept in the bench.
module sim_ipc_mailbox;
    localparam int NM = 4;
    localparam int NU = 2;
    localparam int DP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mq [NM][$];
    logic [7:0]  st [NU];
    logic [7:0]  en [NU];

    ipc_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    function automatic logic [8:0] a_msg(int m);   return 9'('h40 + 4*m);   endfunction
    function automatic logic [8:0] a_full(int m);  return 9'('h80 + 4*m);   endfunction
    function automatic logic [8:0] a_cnt(int m);   return 9'('hC0 + 4*m);   endfunction
    function automatic logic [8:0] a_stat(int u);  return 9'('h104 + 16*u); endfunction
    function automatic logic [8:0] a_enset(int u); return 9'('h108 + 16*u); endfunction
    function automatic logic [8:0] a_enclr(int u); return 9'('h10C + 16*u); endfunction

    function automatic logic [1:0] exp_irq();
        logic [1:0] r;
        for (int u = 0; u < NU; u++) r[u] = |(st[u] & en[u]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic m_push(input int m, input logic [31:0] d);
        do_write(a_msg(m), d);
        if (mq[m].size() < DP) begin
            mq[m].push_back(d);
            for (int u = 0; u < NU; u++) st[u][2*m] = 1'b1;
        end
        chk("R9 irq after push", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic m_pop(input int m);
        logic [31:0] d, e;
        do_read(a_msg(m), d);
        e = 32'h0;
        if (mq[m].size() > 0) begin
            e = mq[m].pop_front();
            for (int u = 0; u < NU; u++) st[u][2*m+1] = 1'b1;
        end
        chk("R4 pop data", d, e);
        chk("R9 irq after pop", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic m_reg(input string req, input logic [8:0] a, input logic [31:0] e);
        logic [31:0] d;
        do_read(a, d);
        chk(req, d, e);
    endtask

    task automatic m_w1c(input int u, input logic [7:0] d);
        do_write(a_stat(u), 32'(d));
        st[u] = st[u] & ~d;
        chk("R7 R9 irq after clear", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic m_en(input int u, input bit set, input logic [7:0] d);
        do_write(set ? a_enset(u) : a_enclr(u), 32'(d));
        en[u] = set ? (en[u] | d) : (en[u] & ~d);
        chk("R8 R9 irq after enable", 32'(irq_o), 32'(exp_irq()));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int u = 0; u < NU; u++) begin st[u] = '0; en[u] = '0; end
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        for (int m = 0; m < NM; m++) begin
            m_reg("R1 count", a_cnt(m), 32'h0);
            m_reg("R1 full", a_full(m), 32'h0);
        end
        for (int u = 0; u < NU; u++) begin
            m_reg("R1 status", a_stat(u), 32'h0);
            m_reg("R1 enable", a_enset(u), 32'h0);
        end

        // R2: version
        m_reg("R2 version", 9'h000, 32'h21);

        // R3 R5: fill mailbox 1, then overflow
        for (int i = 0; i < DP; i++) m_push(1, 32'hA000_0000 + 32'(i));
        m_reg("R5 full flag", a_full(1), 32'h1);
        m_reg("R5 count full", a_cnt(1), 32'(DP));
        m_push(1, 32'hDEAD_BEEF);
        m_reg("R3 count after dropped write", a_cnt(1), 32'(DP));
        m_pop(1);
        m_reg("R5 not full after pop", a_full(1), 32'h0);
        for (int i = 1; i < DP; i++) m_pop(1);
        m_pop(1);
        m_reg("R4 count after empty read", a_cnt(1), 32'h0);

        // R6 R7 R8 R9: events, clears, enables
        m_reg("R6 status user0", a_stat(0), 32'(st[0]));
        m_reg("R6 status user1", a_stat(1), 32'(st[1]));
        m_en(0, 1'b1, 8'h04);
        chk("R9 only user0 line", 32'(irq_o), 32'h1);
        m_reg("R8 enable set readback", a_enset(0), 32'h04);
        m_reg("R8 enable clr readback", a_enclr(0), 32'h04);
        m_w1c(0, 8'h00);
        m_reg("R7 zero write keeps status", a_stat(0), 32'(st[0]));
        m_w1c(0, 8'h04);
        chk("R7 clear drops line", 32'(irq_o), 32'h0);
        m_reg("R7 user1 untouched", a_stat(1), 32'(st[1]));
        m_en(0, 1'b0, 8'hFF);

        // R10: unmapped, misaligned and read-only targets
        m_reg("R10 unmapped 0x010", 9'h010, 32'h0);
        m_reg("R10 unmapped 0x100", 9'h100, 32'h0);
        m_reg("R10 beyond map 0x130", 9'h130, 32'h0);
        m_reg("R10 misaligned 0x042", 9'h042, 32'h0);
        do_write(a_cnt(0), 32'hFFFF_FFFF);
        do_write(a_full(0), 32'hFFFF_FFFF);
        do_write(9'h000, 32'h0000_00FF);
        do_write(9'h044 + 9'h1, 32'h1234_5678);
        m_reg("R10 count unchanged", a_cnt(0), 32'h0);
        m_reg("R10 misaligned write no push", a_cnt(1), 32'h0);
        m_reg("R10 version unchanged", 9'h000, 32'h21);

        // R11: simultaneous write and read
        @(negedge clk);
        bus_addr = a_msg(2); bus_we = 1'b1; bus_re = 1'b1; bus_wdata = 32'h5555_AAAA;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        mq[2].push_back(32'h5555_AAAA);
        for (int u = 0; u < NU; u++) st[u][4] = 1'b1;
        chk("R11 rdata held", bus_rdata, 32'h21);
        m_reg("R11 write took effect", a_cnt(2), 32'h1);
        m_pop(2);

        // Random traffic
        for (int i = 0; i < 1500; i++) begin
            int op, m, u;
            op = int'($urandom_range(0, 9));
            m  = int'($urandom_range(0, NM-1));
            u  = int'($urandom_range(0, NU-1));
            case (op)
                0, 1, 2: m_push(m, $urandom());
                3, 4:    m_pop(m);
                5:       m_reg("R5 random count", a_cnt(m), 32'(mq[m].size()));
                6:       m_reg("R5 random full", a_full(m), 32'(mq[m].size() == DP));
                7:       m_en(u, $urandom_range(0, 1) == 1, 8'($urandom()));
                8:       m_w1c(u, 8'($urandom()));
                default: m_reg("R6 random status", a_stat(u), 32'(st[u]));
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule